// File: doc/BRIEF.md
# Micro-Operation Register Datapath for an Accumulator Machine

This block holds the working registers of a small accumulator machine and carries out the register transfers named by one microinstruction per clock. Each microinstruction supplies three 3-bit micro-operation fields. The fields are decoded side by side, and every transfer they select takes place on the same rising edge. The registers are a 16-bit accumulator, a 16-bit data register, an 11-bit address register and an 11-bit program counter.

The block drives a 2048-word by 16-bit memory. The address always comes from the address register and the write data always comes from the data register. Read data arrives combinationally within the cycle. A separate microprogram sequencer uses four status values that the block exports: the accumulator sign, the accumulator zero flag, the data register's indirect bit, and its opcode nibble. The machine word layout is bit 15 indirect, bits 14:11 opcode and bits 10:0 address. The sequencer and the control store sit outside this block.

Top module: `uop_accum_core`

## Requirements
- R1: After reset, all four registers are zero and the write strobe is low.
- R2: First field `f1`: 000 no effect; 001 AC gets AC+DR; 010 AC gets 0; 011 AC gets AC+1; 100 AC gets DR; 101 AR gets DR[10:0]; 110 AR gets PC; 111 memory write.
- R3: Second field `f2`: 000 no effect; 001 AC gets AC−DR (modulo 2^16); 010 AC gets AC OR DR; 011 AC gets AC AND DR; 100 DR gets memory read data; 101 DR gets AC; 110 DR gets DR+1; 111 see R8.
- R4: Third field `f3`: 000 no effect; 001 AC gets AC XOR DR; 010 AC gets NOT AC; 011 AC shifts left; 100 AC shifts right; 101 PC gets PC+1; 110 PC gets AR; 111 is reserved and changes no register.
- R5: When more than one field writes AC in one cycle, `f3` wins over `f2`, and `f2` wins over `f1`.
- R6: All transfers read values from before the edge. So `f1`=100 together with `f2`=101 swaps AC and DR.
- R7: Both shifts are logical. The vacated bit (bit 0 for left, bit 15 for right) is filled with 0.
- R8: `f2`=111 loads DR[10:0] from PC and leaves DR[15:11] unchanged.
- R9: When `f2`=100, DR captures `memRdData` on the same edge that ends the cycle.
- R10: `memWrEn` is high exactly in the cycles where `f1`=111. In those cycles `memAddr` equals AR and `memWrData` equals DR. Outside write cycles, these two ports still show AR and DR.
- R11: `acSign` is AC[15], `acZero` is high when AC is 0, `drIndirect` is DR[15], and `drOpcode` is DR[14:11].
- R12: Transfers to different registers, selected by different fields, all take effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| f1 | input | 3 | First micro-operation field |
| f2 | input | 3 | Second micro-operation field |
| f3 | input | 3 | Third micro-operation field |
| memRdData | input | 16 | Memory read data, valid in the same cycle |
| memAddr | output | 11 | Memory address (AR) |
| memWrData | output | 16 | Memory write data (DR) |
| memWrEn | output | 1 | Memory write strobe |
| acSign | output | 1 | Accumulator bit 15 |
| acZero | output | 1 | Accumulator equals zero |
| drIndirect | output | 1 | Data register bit 15 |
| drOpcode | output | 4 | Data register bits 14:11 |

## Verification
Some rules can be checked on every cycle from the decoded strobes and the register values one edge later. These are the swap, the clear, the zero-filled shifts, the program counter increment, the same-edge capture of read data, and the preservation of the data register's upper bits. Other properties need chosen operand pairs whose results differ, so only the bench's scenarios can show them. These are the arithmetic and logic results, the priority among the three fields when they compete for the accumulator, the reserved code having no effect, and simultaneous transfers to separate registers. The bench reads the accumulator and program counter back through the memory ports by issuing transfers, so every result is observed at the block's pins.

// File: rtl/uop_core_pkg.sv
package uop_core_pkg;

  typedef enum logic [3:0] {
    AC_HOLD, AC_ADD, AC_CLR, AC_INC, AC_LDDR, AC_SUB,
    AC_OR, AC_AND, AC_XOR, AC_NOT, AC_SHL, AC_SHR
  } acOp_e;

  typedef enum logic [2:0] {
    DR_HOLD, DR_MEM, DR_AC, DR_INC, DR_PC
  } drOp_e;

  typedef enum logic [1:0] {
    AR_HOLD, AR_DR, AR_PC
  } arOp_e;

  typedef enum logic [1:0] {
    PC_HOLD, PC_INC, PC_AR
  } pcOp_e;

  typedef struct packed {
    acOp_e acOp;
    drOp_e drOp;
    arOp_e arOp;
    pcOp_e pcOp;
    logic  memWr;
  } ctrlStrobes_t;

endpackage

// File: rtl/uop_field_decode.sv
module uop_field_decode
  import uop_core_pkg::*;
(
  input  logic [2:0]   f1,
  input  logic [2:0]   f2,
  input  logic [2:0]   f3,
  output ctrlStrobes_t ctrl
);

  acOp_e acFromF1, acFromF2, acFromF3;

  // first field: accumulator, address register, write strobe
  always_comb begin
    acFromF1   = AC_HOLD;
    ctrl.arOp  = AR_HOLD;
    ctrl.memWr = 1'b0;
    unique case (f1)
      3'b001:  acFromF1   = AC_ADD;
      3'b010:  acFromF1   = AC_CLR;
      3'b011:  acFromF1   = AC_INC;
      3'b100:  acFromF1   = AC_LDDR;
      3'b101:  ctrl.arOp  = AR_DR;
      3'b110:  ctrl.arOp  = AR_PC;
      3'b111:  ctrl.memWr = 1'b1;
      default: ;
    endcase
  end

  // second field: accumulator logic ops and data register loads
  always_comb begin
    acFromF2  = AC_HOLD;
    ctrl.drOp = DR_HOLD;
    unique case (f2)
      3'b001:  acFromF2  = AC_SUB;
      3'b010:  acFromF2  = AC_OR;
      3'b011:  acFromF2  = AC_AND;
      3'b100:  ctrl.drOp = DR_MEM;
      3'b101:  ctrl.drOp = DR_AC;
      3'b110:  ctrl.drOp = DR_INC;
      3'b111:  ctrl.drOp = DR_PC;
      default: ;
    endcase
  end

  // third field: accumulator unary ops and program counter; 111 reserved
  always_comb begin
    acFromF3  = AC_HOLD;
    ctrl.pcOp = PC_HOLD;
    unique case (f3)
      3'b001:  acFromF3  = AC_XOR;
      3'b010:  acFromF3  = AC_NOT;
      3'b011:  acFromF3  = AC_SHL;
      3'b100:  acFromF3  = AC_SHR;
      3'b101:  ctrl.pcOp = PC_INC;
      3'b110:  ctrl.pcOp = PC_AR;
      default: ;
    endcase
  end

  // fixed accumulator write priority: third over second over first (R5)
  always_comb begin
    if (acFromF3 != AC_HOLD)      ctrl.acOp = acFromF3;
    else if (acFromF2 != AC_HOLD) ctrl.acOp = acFromF2;
    else                          ctrl.acOp = acFromF1;
  end

endmodule

// File: rtl/uop_reg_datapath.sv
module uop_reg_datapath
  import uop_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobes_t               ctrl,
  input  logic [DATA_W-1:0]          memRdData,
  output logic [ADDR_W-1:0]          memAddr,
  output logic [DATA_W-1:0]          memWrData,
  output logic                       memWrEn,
  output logic                       acSign,
  output logic                       acZero,
  output logic                       drIndirect,
  output logic [DATA_W-ADDR_W-2:0]   drOpcode
);

  localparam int OP_W = DATA_W - ADDR_W - 1;

  logic [DATA_W-1:0] acReg, drReg, acNext, drNext;
  logic [ADDR_W-1:0] arReg, pcReg, arNext, pcNext;

  always_comb begin
    unique case (ctrl.acOp)
      AC_ADD:  acNext = acReg + drReg;
      AC_CLR:  acNext = '0;
      AC_INC:  acNext = acReg + DATA_W'(1);
      AC_LDDR: acNext = drReg;
      AC_SUB:  acNext = acReg - drReg;
      AC_OR:   acNext = acReg | drReg;
      AC_AND:  acNext = acReg & drReg;
      AC_XOR:  acNext = acReg ^ drReg;
      AC_NOT:  acNext = ~acReg;
      AC_SHL:  acNext = {acReg[DATA_W-2:0], 1'b0};
      AC_SHR:  acNext = {1'b0, acReg[DATA_W-1:1]};
      default: acNext = acReg;
    endcase
  end

  always_comb begin
    drNext = drReg;
    unique case (ctrl.drOp)
      DR_MEM:  drNext = memRdData;
      DR_AC:   drNext = acReg;
      DR_INC:  drNext = drReg + DATA_W'(1);
      DR_PC:   drNext[ADDR_W-1:0] = pcReg;
      default: ;
    endcase
  end

  always_comb begin
    unique case (ctrl.arOp)
      AR_DR:   arNext = drReg[ADDR_W-1:0];
      AR_PC:   arNext = pcReg;
      default: arNext = arReg;
    endcase
  end

  always_comb begin
    unique case (ctrl.pcOp)
      PC_INC:  pcNext = pcReg + ADDR_W'(1);
      PC_AR:   pcNext = arReg;
      default: pcNext = pcReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acReg <= '0;
      drReg <= '0;
      arReg <= '0;
      pcReg <= '0;
    end else begin
      acReg <= acNext;
      drReg <= drNext;
      arReg <= arNext;
      pcReg <= pcNext;
    end
  end

  assign memAddr    = arReg;
  assign memWrData  = drReg;
  assign memWrEn    = ctrl.memWr;
  assign acSign     = acReg[DATA_W-1];
  assign acZero     = (acReg == '0);
  assign drIndirect = drReg[DATA_W-1];
  assign drOpcode   = drReg[DATA_W-2 -: OP_W];

  assert_swap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.acOp == AC_LDDR && ctrl.drOp == DR_AC)
      |=> (acReg == $past(drReg) && drReg == $past(acReg)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.acOp == AC_CLR) |=> (acReg == '0));

  assert_shl_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.acOp == AC_SHL) |=> (acReg[0] == 1'b0 &&
      acReg[DATA_W-1:1] == $past(acReg[DATA_W-2:0])));

  assert_shr_fill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.acOp == AC_SHR) |=> (acReg[DATA_W-1] == 1'b0 &&
      acReg[DATA_W-2:0] == $past(acReg[DATA_W-1:1])));

  assert_dr_upper_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.drOp == DR_PC) |=> (drReg[DATA_W-1:ADDR_W] == $past(drReg[DATA_W-1:ADDR_W])
      && drReg[ADDR_W-1:0] == $past(pcReg)));

  assert_mem_capture_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.drOp == DR_MEM) |=> (drReg == $past(memRdData)));

  assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.pcOp == PC_INC) |=> (pcReg == $past(pcReg) + ADDR_W'(1)));

endmodule

// File: rtl/uop_accum_core.sv
module uop_accum_core
  import uop_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [2:0]                f1,
  input  logic [2:0]                f2,
  input  logic [2:0]                f3,
  input  logic [DATA_W-1:0]         memRdData,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [DATA_W-1:0]         memWrData,
  output logic                      memWrEn,
  output logic                      acSign,
  output logic                      acZero,
  output logic                      drIndirect,
  output logic [DATA_W-ADDR_W-2:0]  drOpcode
);

  ctrlStrobes_t ctrl;

  uop_field_decode u_decode (
    .f1   (f1),
    .f2   (f2),
    .f3   (f3),
    .ctrl (ctrl)
  );

  uop_reg_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .memRdData  (memRdData),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .memWrEn    (memWrEn),
    .acSign     (acSign),
    .acZero     (acZero),
    .drIndirect (drIndirect),
    .drOpcode   (drOpcode)
  );

  // the strobe follows the first field combinationally, with no register (R10)
  assert_wr_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    (f1 == 3'b111) |-> memWrEn);

endmodule

// File: tb/uop_accum_core_bench.sv
`timescale 1ns/1ps
module uop_accum_core_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  f1 = '0, f2 = '0, f3 = '0;
  logic [15:0] memRdData = '0;
  logic [10:0] memAddr;
  logic [15:0] memWrData;
  logic        memWrEn, acSign, acZero, drIndirect;
  logic [3:0]  drOpcode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uop_accum_core u_uop_accum_core (
    .clk(clk), .rstN(rstN), .f1(f1), .f2(f2), .f3(f3),
    .memRdData(memRdData), .memAddr(memAddr), .memWrData(memWrData),
    .memWrEn(memWrEn), .acSign(acSign), .acZero(acZero),
    .drIndirect(drIndirect), .drOpcode(drOpcode)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  a, b, c;
    logic [15:0] acIn, drIn, expAc, expDr;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VECS [NVEC] = '{
    '{4'd2,  3'd1, 3'd0, 3'd0, 16'h00F0, 16'h0F0F, 16'h0FFF, 16'h0F0F}, // R2 add
    '{4'd2,  3'd2, 3'd0, 3'd0, 16'h00F0, 16'h0F0F, 16'h0000, 16'h0F0F}, // R2 clear
    '{4'd2,  3'd3, 3'd0, 3'd0, 16'h00F0, 16'h0F0F, 16'h00F1, 16'h0F0F}, // R2 inc
    '{4'd2,  3'd4, 3'd0, 3'd0, 16'h00F0, 16'h0F0F, 16'h0F0F, 16'h0F0F}, // R2 AC<-DR
    '{4'd3,  3'd0, 3'd1, 3'd0, 16'h00F0, 16'h0F0F, 16'hF1E1, 16'h0F0F}, // R3 sub
    '{4'd3,  3'd0, 3'd2, 3'd0, 16'h00F0, 16'h0F0F, 16'h0FFF, 16'h0F0F}, // R3 or
    '{4'd3,  3'd0, 3'd3, 3'd0, 16'h00F0, 16'h0F0F, 16'h0000, 16'h0F0F}, // R3 and
    '{4'd3,  3'd0, 3'd5, 3'd0, 16'h00F0, 16'h0F0F, 16'h00F0, 16'h00F0}, // R3 DR<-AC
    '{4'd3,  3'd0, 3'd6, 3'd0, 16'h00F0, 16'h0F0F, 16'h00F0, 16'h0F10}, // R3 DR+1
    '{4'd4,  3'd0, 3'd0, 3'd1, 16'h00F0, 16'h0F0F, 16'h0FFF, 16'h0F0F}, // R4 xor
    '{4'd4,  3'd0, 3'd0, 3'd2, 16'h00F0, 16'h0F0F, 16'hFF0F, 16'h0F0F}, // R4 not
    '{4'd7,  3'd0, 3'd0, 3'd3, 16'h8001, 16'h0F0F, 16'h0002, 16'h0F0F}, // R7 shl
    '{4'd7,  3'd0, 3'd0, 3'd4, 16'h8001, 16'h0F0F, 16'h4000, 16'h0F0F}, // R7 shr
    '{4'd4,  3'd0, 3'd0, 3'd7, 16'h00F0, 16'h0F0F, 16'h00F0, 16'h0F0F}, // R4 reserved
    '{4'd5,  3'd1, 3'd2, 3'd2, 16'h00F0, 16'h0F0F, 16'hFF0F, 16'h0F0F}, // R5 f3 wins
    '{4'd5,  3'd3, 3'd1, 3'd0, 16'h00F0, 16'h0F0F, 16'hF1E1, 16'h0F0F}, // R5 f2 over f1
    '{4'd5,  3'd4, 3'd3, 3'd0, 16'h00F0, 16'h0F0F, 16'h0000, 16'h0F0F}, // R5 and over load
    '{4'd6,  3'd4, 3'd5, 3'd0, 16'h00F0, 16'h0F0F, 16'h0F0F, 16'h00F0}, // R6 swap
    '{4'd12, 3'd0, 3'd5, 3'd1, 16'h00F0, 16'h0F0F, 16'h0FFF, 16'h00F0}, // R12 pre-edge
    '{4'd2,  3'd0, 3'd0, 3'd0, 16'h00F0, 16'h0F0F, 16'h00F0, 16'h0F0F}  // R2 no-op
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply one microinstruction for one clock, return after the following falling edge
  task automatic uop(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c,
                     input logic [15:0] rd);
    f1 = a; f2 = b; f3 = c; memRdData = rd;
    @(posedge clk);
    @(negedge clk);
    f1 = '0; f2 = '0; f3 = '0; memRdData = '0;
  endtask

  task automatic loadDr(input logic [15:0] v);
    uop(3'd0, 3'd4, 3'd0, v);
  endtask

  task automatic loadAc(input logic [15:0] v);
    loadDr(v);
    uop(3'd4, 3'd0, 3'd0, 16'h0);
  endtask

  task automatic readAc(output logic [15:0] v);
    uop(3'd0, 3'd5, 3'd0, 16'h0);
    v = memWrData;
  endtask

  task automatic readPc(output logic [10:0] v);
    uop(3'd6, 3'd0, 3'd0, 16'h0);
    v = memAddr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] acVal;
    logic [10:0] pcVal;
    repeat (3) @(negedge clk);
    // R1 reset state, before releasing reset and just after
    check("R1 AR", {5'd0, memAddr}, 16'h0);
    check("R1 DR", memWrData, 16'h0);
    check("R1 wr", {15'd0, memWrEn}, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 acZero", {15'd0, acZero}, 16'h1);
    check("R1 acSign", {15'd0, acSign}, 16'h0);
    readAc(acVal);
    check("R1 AC", acVal, 16'h0);
    readPc(pcVal);
    check("R1 PC", {5'd0, pcVal}, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      loadAc(VECS[i].acIn);
      loadDr(VECS[i].drIn);
      uop(VECS[i].a, VECS[i].b, VECS[i].c, 16'h0);
      checks++;
      if (memWrData !== VECS[i].expDr) begin
        errors++;
        $display("FAIL R%0d vec %0d DR actual %h expected %h", VECS[i].req, i, memWrData, VECS[i].expDr);
      end
      // R11 status flags follow the registers
      check("R11 acSign", {15'd0, acSign}, {15'd0, VECS[i].expAc[15]});
      check("R11 acZero", {15'd0, acZero}, {15'd0, VECS[i].expAc == 16'h0});
      check("R11 drIndirect", {15'd0, drIndirect}, {15'd0, VECS[i].expDr[15]});
      check("R11 drOpcode", {12'd0, drOpcode}, {12'd0, VECS[i].expDr[14:11]});
      readAc(acVal);
      checks++;
      if (acVal !== VECS[i].expAc) begin
        errors++;
        $display("FAIL R%0d vec %0d AC actual %h expected %h", VECS[i].req, i, acVal, VECS[i].expAc);
      end
    end

    // R9 read data captured on the same edge; R11 fields of the loaded word
    loadDr(16'hABCD);
    check("R9 read capture", memWrData, 16'hABCD);
    check("R11 indirect bit", {15'd0, drIndirect}, 16'h1);
    check("R11 opcode nibble", {12'd0, drOpcode}, 16'h0005);
    // R2 AR gets DR low bits
    uop(3'd5, 3'd0, 3'd0, 16'h0);
    check("R2 AR<-DR", {5'd0, memAddr}, 16'h03CD);
    // R4 PC gets AR, then PC increments
    uop(3'd0, 3'd0, 3'd6, 16'h0);
    readPc(pcVal);
    check("R4 PC<-AR", {5'd0, pcVal}, 16'h03CD);
    uop(3'd0, 3'd0, 3'd5, 16'h0);
    readPc(pcVal);
    check("R4 PC+1", {5'd0, pcVal}, 16'h03CE);
    // R8 DR low bits from PC, upper bits kept
    loadDr(16'hFFFF);
    uop(3'd0, 3'd7, 3'd0, 16'h0);
    check("R8 DR<-PC", memWrData, 16'hFBCE);
    // R12 three registers updated by three fields in one cycle
    uop(3'd6, 3'd6, 3'd5, 16'h0);
    check("R12 AR", {5'd0, memAddr}, 16'h03CE);
    check("R12 DR", memWrData, 16'hFBCF);
    readPc(pcVal);
    check("R12 PC", {5'd0, pcVal}, 16'h03CF);
    // R10 write strobe only in the f1=111 cycle, address AR, data DR
    loadDr(16'h5A5A);
    f1 = 3'd6;
    #1;
    check("R10 no strobe f1=110", {15'd0, memWrEn}, 16'h0);
    f1 = 3'd7;
    #1;
    check("R10 strobe", {15'd0, memWrEn}, 16'h1);
    check("R10 addr", {5'd0, memAddr}, 16'h03CF);
    check("R10 data", memWrData, 16'h5A5A);
    @(posedge clk);
    @(negedge clk);
    f1 = 3'd0;
    #1;
    check("R10 strobe drops", {15'd0, memWrEn}, 16'h0);
    check("R10 regs kept", memWrData, 16'h5A5A);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule